// File: doc/BRIEF.md
# Fan PWM Channel Controller

This block drives one cooling fan. It makes a pulse-width modulated output and picks the duty cycle from one of several places. Those places are three temperature-derived duty requests, the larger or largest of a group of them, a fixed full speed, off, or a duty byte that software writes. A duty ramp moves the applied duty toward the selected value one step at a time. A slow flag stretches each step to four times its normal length.

When the fan is switched on from the off state, the output is driven fully on until the fan proves it is turning. The proof is two debounced rising edges on the tachometer input. A selectable millisecond timeout can also end this phase. When the timeout ends it without that proof, the reported tach period reads all ones and a fan fault is raised. The fault is held back when the tach limit is all zeros or all ones. A global lock input freezes the configuration byte and the manual duty byte. The block also measures and reports the tach period.

Top module: `fan_pwm_channel`

## Requirements
- R1: After reset the register reads are: configuration byte (address 0) 0x82, manual duty (address 1) 0x00, tach limit low and high bytes (addresses 2 and 3) 0xFF. After reset the PWM output is low, the fault output is low and the tach period output is 0xFFFF.
- R2: The configuration byte is laid out as follows. Bits [7:5] are the behaviour code, bit 4 is inversion, bit 3 is the slow-ramp flag and bits [2:0] are the timeout code. Timeout codes 1..7 end the spin-up phase after 100, 250, 400, 667, 1000, 2000 and 4000 millisecond ticks. Code 0 sets no time limit.
- R3: When the behaviour code changes from 100 (off) to any other value, the output is held at 100% duty from the next cycle. It stays there until the second valid tach rising edge seen during spin-up.
- R4: The tach period output gives the number of clock-enable ticks between consecutive valid rising edges, saturating at 0xFFFF. After a spin-up timeout without two edges it reads 0xFFFF until the next valid edge.
- R5: A spin-up timeout that arrives before the second edge raises the fault output, unless the 16-bit tach limit is 0x0000 or 0xFFFF. The fault clears on the next valid edge or when the channel is switched off.
- R6: Behaviour codes select the duty target as follows: 000 input A, 001 local input, 010 input B, 011 0xFF, 100 off, 101 the larger of local and B, 110 the largest of all three, 111 the manual duty byte.
- R7: The PWM counter runs over 256 ticks. The raw output is high while the counter is below the applied duty, and it is constantly high at duty 0xFF. With inversion set, the output is the complement of the raw output.
- R8: While the lock input is high, writes to the configuration byte leave it unchanged.
- R9: The manual duty byte accepts a write only when the behaviour code is 111 and the lock input is low.
- R10: The applied duty moves by one toward the target on each ramp step. A step happens on every millisecond tick, or on every fourth tick when the slow flag is set.
- R11: The tach input passes through two synchronising flip-flops. A rising edge counts as valid only after the synchronised level has differed from the filtered level for 4 consecutive cycles.
- R12: With behaviour code 100 the applied duty is 0% at once, so the output equals the inversion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i |
| lock_i | input | 1 | Global configuration lock |
| duty_a_i | input | 8 | Duty request from sensor A |
| duty_loc_i | input | 8 | Duty request from the local sensor |
| duty_b_i | input | 8 | Duty request from sensor B |
| tach_i | input | 1 | Asynchronous tachometer input |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| pwm_o | output | 1 | Fan drive output |
| fan_fault_o | output | 1 | Fan failed to start |
| tach_period_o | output | 16 | Measured tach period |

## Verification
The assertions check these on every cycle: the off mode drives the inversion level, the spin-up phase drives full duty, a raised fault always comes with a saturated period, a fault only rises under a valid limit, the ramp moves by at most one step per cycle, and locked or wrong-mode writes leave their register unchanged. Only the bench scenarios can show the rest. That covers the measured duty over a full period in each behaviour code, the exact timeout length, the period value, glitch rejection on the tach input, and the four-times stretch of the slow ramp.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

    typedef enum logic [2:0] {
        BHV_SENS_A  = 3'b000,
        BHV_LOCAL   = 3'b001,
        BHV_SENS_B  = 3'b010,
        BHV_FULL    = 3'b011,
        BHV_OFF     = 3'b100,
        BHV_MAX_LB  = 3'b101,
        BHV_MAX_ALL = 3'b110,
        BHV_MANUAL  = 3'b111
    } bhv_e;

    typedef struct packed {
        bhv_e       bhv;
        logic       invert;
        logic       slow;
        logic [2:0] tmo;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        SP_IDLE = 2'd0,
        SP_KICK = 2'd1,
        SP_RUN  = 2'd2
    } spin_e;

    localparam logic [7:0]  CFG_RST      = 8'h82;
    localparam logic [1:0]  ADDR_CFG     = 2'd0;
    localparam logic [1:0]  ADDR_MAN     = 2'd1;
    localparam logic [1:0]  ADDR_LIM_LO  = 2'd2;
    localparam logic [1:0]  ADDR_LIM_HI  = 2'd3;
    localparam int          MS_W         = 12;

    function automatic logic [MS_W-1:0] tmo_ms(input logic [2:0] code);
        logic [MS_W-1:0] r;
        case (code)
            3'd1:    r = 12'd100;
            3'd2:    r = 12'd250;
            3'd3:    r = 12'd400;
            3'd4:    r = 12'd667;
            3'd5:    r = 12'd1000;
            3'd6:    r = 12'd2000;
            3'd7:    r = 12'd4000;
            default: r = 12'd0;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] max2(input logic [7:0] a, input logic [7:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fan_tach_meter.sv
module fan_tach_meter #(
    parameter int DEB_CYCLES = 4,
    parameter int PER_W      = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ce_i,
    input  logic             tach_i,
    output logic             edge_o,
    output logic [PER_W-1:0] period_o
);
    localparam int DBW = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [DBW-1:0]   DEB_LAST = DBW'(DEB_CYCLES - 1);
    localparam logic [PER_W-1:0] PER_SAT  = '1;

    logic             sync1_q, sync2_q, filt_q;
    logic [DBW-1:0]   dbc_q;
    logic [PER_W-1:0] per_q, period_q;

    assign edge_o   = sync2_q && !filt_q && (dbc_q == DEB_LAST);
    assign period_o = period_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= tach_i;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            filt_q <= 1'b0;
            dbc_q  <= '0;
        end else if (sync2_q == filt_q) begin
            dbc_q <= '0;
        end else if (dbc_q == DEB_LAST) begin
            filt_q <= sync2_q;
            dbc_q  <= '0;
        end else begin
            dbc_q <= dbc_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            per_q    <= '0;
            period_q <= PER_SAT;
        end else begin
            if (edge_o) begin
                per_q    <= '0;
                period_q <= (per_q == PER_SAT) ? PER_SAT : per_q + 1'b1;
            end else if (ce_i && per_q != PER_SAT) begin
                per_q <= per_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fan_spinup_ctrl.sv
module fan_spinup_ctrl
    import fan_pwm_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        off_i,
    input  logic [2:0]  tmo_i,
    input  logic [15:0] lim_i,
    input  logic        ms_tick_i,
    input  logic        edge_i,
    output logic        full_o,
    output logic        forced_o,
    output logic        fault_o,
    output spin_e       state_o
);
    spin_e           state_q;
    logic            edges_q;
    logic [MS_W-1:0] ms_q;
    logic            forced_q, fault_q;
    logic            hit, lim_ok;

    assign hit     = (tmo_i != 3'd0) && ms_tick_i && (ms_q == tmo_ms(tmo_i) - 1'b1);
    assign lim_ok  = (lim_i != 16'h0000) && (lim_i != 16'hFFFF);
    assign full_o  = ((state_q == SP_IDLE) && !off_i) || (state_q == SP_KICK);
    assign forced_o = forced_q;
    assign fault_o  = fault_q;
    assign state_o  = state_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q  <= SP_IDLE;
            edges_q  <= 1'b0;
            ms_q     <= '0;
            forced_q <= 1'b0;
            fault_q  <= 1'b0;
        end else begin
            if (edge_i) begin
                forced_q <= 1'b0;
                fault_q  <= 1'b0;
            end
            unique case (state_q)
                SP_IDLE: begin
                    forced_q <= 1'b0;
                    fault_q  <= 1'b0;
                    if (!off_i) begin
                        state_q <= SP_KICK;
                        edges_q <= 1'b0;
                        ms_q    <= '0;
                    end
                end
                SP_KICK: begin
                    if (off_i) begin
                        state_q  <= SP_IDLE;
                        forced_q <= 1'b0;
                        fault_q  <= 1'b0;
                    end else if (edge_i && edges_q) begin
                        state_q <= SP_RUN;
                    end else begin
                        if (edge_i) edges_q <= 1'b1;
                        if (ms_tick_i) ms_q <= ms_q + 1'b1;
                        if (hit) begin
                            state_q  <= SP_RUN;
                            forced_q <= 1'b1;
                            fault_q  <= lim_ok;
                        end
                    end
                end
                default: begin
                    if (off_i) begin
                        state_q  <= SP_IDLE;
                        forced_q <= 1'b0;
                        fault_q  <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fan_duty_path.sv
module fan_duty_path
    import fan_pwm_pkg::*;
#(
    parameter int RAMP_MS = 1
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  bhv_e       bhv_i,
    input  logic       slow_i,
    input  logic       ms_tick_i,
    input  logic [7:0] duty_a_i,
    input  logic [7:0] duty_loc_i,
    input  logic [7:0] duty_b_i,
    input  logic [7:0] duty_man_i,
    output logic [7:0] ramp_o
);
    localparam int RDW = $clog2(4 * RAMP_MS + 1);
    localparam logic [RDW-1:0] FAST_LAST = RDW'(RAMP_MS - 1);
    localparam logic [RDW-1:0] SLOW_LAST = RDW'(4 * RAMP_MS - 1);

    logic [7:0]     target;
    logic [7:0]     ramp_q;
    logic [RDW-1:0] rdiv_q;
    logic [RDW-1:0] rdiv_last;
    logic           step;

    always_comb begin
        unique case (bhv_i)
            BHV_SENS_A:  target = duty_a_i;
            BHV_LOCAL:   target = duty_loc_i;
            BHV_SENS_B:  target = duty_b_i;
            BHV_FULL:    target = 8'hFF;
            BHV_MAX_LB:  target = max2(duty_loc_i, duty_b_i);
            BHV_MAX_ALL: target = max2(duty_a_i, max2(duty_loc_i, duty_b_i));
            BHV_MANUAL:  target = duty_man_i;
            default:     target = 8'h00;
        endcase
    end

    assign rdiv_last = slow_i ? SLOW_LAST : FAST_LAST;
    assign step      = ms_tick_i && (rdiv_q >= rdiv_last);
    assign ramp_o    = ramp_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || bhv_i == BHV_OFF) begin
            ramp_q <= 8'h00;
            rdiv_q <= '0;
        end else if (ms_tick_i) begin
            rdiv_q <= step ? '0 : rdiv_q + 1'b1;
            if (step) begin
                if (ramp_q < target)      ramp_q <= ramp_q + 1'b1;
                else if (ramp_q > target) ramp_q <= ramp_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/fan_pwm_channel.sv
module fan_pwm_channel
    import fan_pwm_pkg::*;
#(
    parameter int PWM_CE_DIV = 1,
    parameter int RAMP_MS    = 1,
    parameter int DEB_CYCLES = 4
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        wr_en_i,
    input  logic [1:0]  addr_i,
    input  logic [7:0]  wr_data_i,
    output logic [7:0]  rd_data_o,
    input  logic        lock_i,
    input  logic [7:0]  duty_a_i,
    input  logic [7:0]  duty_loc_i,
    input  logic [7:0]  duty_b_i,
    input  logic        tach_i,
    input  logic        ms_tick_i,
    output logic        pwm_o,
    output logic        fan_fault_o,
    output logic [15:0] tach_period_o
);
    chan_cfg_t   cfg_q;
    logic [7:0]  man_q;
    logic [15:0] lim_q;
    logic        cfg_we, man_we;
    logic        ce;
    logic [7:0]  cnt_q;
    logic        tach_edge;
    logic [15:0] meas_period;
    logic        off, spin_full, forced;
    spin_e       spin_state;
    logic [7:0]  ramp_duty, duty_eff;
    logic        raw;

    assign cfg_we = wr_en_i && (addr_i == ADDR_CFG) && !lock_i;
    assign man_we = wr_en_i && (addr_i == ADDR_MAN) && !lock_i && (cfg_q.bhv == BHV_MANUAL);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= chan_cfg_t'(CFG_RST);
            man_q <= 8'h00;
            lim_q <= 16'hFFFF;
        end else begin
            if (cfg_we) cfg_q <= chan_cfg_t'(wr_data_i);
            if (man_we) man_q <= wr_data_i;
            if (wr_en_i && addr_i == ADDR_LIM_LO) lim_q[7:0]  <= wr_data_i;
            if (wr_en_i && addr_i == ADDR_LIM_HI) lim_q[15:8] <= wr_data_i;
        end
    end

    always_comb begin
        unique case (addr_i)
            ADDR_CFG:    rd_data_o = cfg_q;
            ADDR_MAN:    rd_data_o = man_q;
            ADDR_LIM_LO: rd_data_o = lim_q[7:0];
            default:     rd_data_o = lim_q[15:8];
        endcase
    end

    generate
        if (PWM_CE_DIV <= 1) begin : g_ce_every
            assign ce = 1'b1;
        end else begin : g_ce_div
            localparam int PSW = $clog2(PWM_CE_DIV);
            logic [PSW-1:0] pre_q;
            assign ce = (pre_q == PSW'(PWM_CE_DIV - 1));
            always_ff @(posedge clk_i) begin
                if (rst_i || ce) pre_q <= '0;
                else             pre_q <= pre_q + 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i)   cnt_q <= 8'h00;
        else if (ce) cnt_q <= cnt_q + 1'b1;
    end

    fan_tach_meter #(.DEB_CYCLES(DEB_CYCLES), .PER_W(16)) u_tach (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .ce_i     (ce),
        .tach_i   (tach_i),
        .edge_o   (tach_edge),
        .period_o (meas_period)
    );

    assign off = (cfg_q.bhv == BHV_OFF);

    fan_spinup_ctrl u_spin (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .off_i     (off),
        .tmo_i     (cfg_q.tmo),
        .lim_i     (lim_q),
        .ms_tick_i (ms_tick_i),
        .edge_i    (tach_edge),
        .full_o    (spin_full),
        .forced_o  (forced),
        .fault_o   (fan_fault_o),
        .state_o   (spin_state)
    );

    fan_duty_path #(.RAMP_MS(RAMP_MS)) u_duty (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .bhv_i      (cfg_q.bhv),
        .slow_i     (cfg_q.slow),
        .ms_tick_i  (ms_tick_i),
        .duty_a_i   (duty_a_i),
        .duty_loc_i (duty_loc_i),
        .duty_b_i   (duty_b_i),
        .duty_man_i (man_q),
        .ramp_o     (ramp_duty)
    );

    assign duty_eff      = off ? 8'h00 : (spin_full ? 8'hFF : ramp_duty);
    assign raw           = (duty_eff == 8'hFF) || (cnt_q < duty_eff);
    assign pwm_o         = raw ^ cfg_q.invert;
    assign tach_period_o = forced ? 16'hFFFF : meas_period;
endmodule

// File: rtl/fan_pwm_channel_chk.sv
module fan_pwm_channel_chk
    import fan_pwm_pkg::*;
(
    input logic        clk_i,
    input logic        rst_i,
    input logic [7:0]  cfg_i,
    input logic [7:0]  man_i,
    input logic [15:0] lim_i,
    input logic [7:0]  ramp_i,
    input spin_e       state_i,
    input logic        lock_i,
    input logic        wr_en_i,
    input logic [1:0]  addr_i,
    input logic        pwm_i,
    input logic        fault_i,
    input logic [15:0] period_i
);
    logic off;
    assign off = (cfg_i[7:5] == 3'b100);

    // R12
    off_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        off |-> (pwm_i == cfg_i[4]));

    // R3
    kick_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == SP_KICK && !off) |-> (pwm_i == !cfg_i[4]));

    // R4
    fault_period_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        fault_i |-> (period_i == 16'hFFFF));

    // R5
    fault_limit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(fault_i) |-> ($past(lim_i) != 16'h0000 && $past(lim_i) != 16'hFFFF));

    // R8
    cfg_lock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (lock_i && wr_en_i && addr_i == ADDR_CFG) |=> $stable(cfg_i));

    // R9
    man_guard_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == ADDR_MAN && (lock_i || cfg_i[7:5] != 3'b111)) |=> $stable(man_i));

    // R10
    ramp_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!off && !$past(off)) |->
        (ramp_i == $past(ramp_i) || ramp_i == $past(ramp_i) + 8'd1 || ramp_i == $past(ramp_i) - 8'd1));
endmodule

bind fan_pwm_channel fan_pwm_channel_chk chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cfg_i    (cfg_q),
    .man_i    (man_q),
    .lim_i    (lim_q),
    .ramp_i   (ramp_duty),
    .state_i  (spin_state),
    .lock_i   (lock_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .pwm_i    (pwm_o),
    .fault_i  (fan_fault_o),
    .period_i (tach_period_o)
);

// File: tb/fan_pwm_channel_tb_top.sv
module fan_pwm_channel_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = 2'd0;
    logic [7:0]  wr_data_i = 8'h00;
    logic        lock_i = 1'b0;
    logic [7:0]  duty_a_i = 8'h00;
    logic [7:0]  duty_loc_i = 8'h00;
    logic [7:0]  duty_b_i = 8'h00;
    logic        tach_i;
    logic        ms_tick_i = 1'b1;
    logic [7:0]  rd_data_o;
    logic        pwm_o;
    logic        fan_fault_o;
    logic [15:0] tach_period_o;

    logic tach_on = 1'b0, tach_r = 1'b0, tach_man = 1'b0;
    int   tach_half = 20, tach_cnt = 0;
    int   checks = 0, errs = 0, cyc = 0;
    bit   done = 0;

    assign tach_i = tach_on ? tach_r : tach_man;

    always #2 clk_i = ~clk_i;

    fan_pwm_channel dut_i (
        .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .lock_i(lock_i),
        .duty_a_i(duty_a_i), .duty_loc_i(duty_loc_i), .duty_b_i(duty_b_i),
        .tach_i(tach_i), .ms_tick_i(ms_tick_i), .pwm_o(pwm_o),
        .fan_fault_o(fan_fault_o), .tach_period_o(tach_period_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    int m_cfg, m_man, m_lim, m_s1, m_s2, m_filt, m_dbc, m_per, m_period, m_cnt;
    int m_ramp, m_rdiv, m_state, m_edges, m_ms, m_force, m_fault;

    function automatic int ms_limit(input int code);
        int t[8] = '{0, 100, 250, 400, 667, 1000, 2000, 4000};
        return t[code];
    endfunction

    function automatic int bigger(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    always @(posedge clk_i) begin
        if (rst_i) begin
            m_cfg = 'h82; m_man = 0; m_lim = 'hFFFF;
            m_s1 = 0; m_s2 = 0; m_filt = 0; m_dbc = 0; m_per = 0; m_period = 'hFFFF;
            m_cnt = 0; m_ramp = 0; m_rdiv = 0; m_state = 0; m_edges = 0; m_ms = 0;
            m_force = 0; m_fault = 0;
        end else begin
            int bhv, ve, tgt, tmo, lim_ok, hit, off;
            int n_cfg, n_man, n_lim, n_state, n_edges, n_ms, n_force, n_fault;
            bhv = (m_cfg >> 5) & 7;
            off = (bhv == 4);
            tmo = m_cfg & 7;
            ve  = (m_s2 == 1 && m_filt == 0 && m_dbc == 3);
            // registers
            n_cfg = m_cfg; n_man = m_man; n_lim = m_lim;
            if (wr_en_i) begin
                if (addr_i == 0 && !lock_i) n_cfg = wr_data_i;
                if (addr_i == 1 && !lock_i && bhv == 7) n_man = wr_data_i;
                if (addr_i == 2) n_lim = (m_lim & 'hFF00) | wr_data_i;
                if (addr_i == 3) n_lim = (m_lim & 'h00FF) | (wr_data_i << 8);
            end
            // tach filter and period
            if (m_s2 == m_filt) m_dbc = 0;
            else if (m_dbc == 3) begin m_filt = m_s2; m_dbc = 0; end
            else m_dbc = m_dbc + 1;
            if (ve) begin
                m_period = (m_per == 'hFFFF) ? 'hFFFF : m_per + 1;
                m_per = 0;
            end else if (m_per != 'hFFFF) m_per = m_per + 1;
            m_s2 = m_s1; m_s1 = tach_i;
            m_cnt = (m_cnt + 1) % 256;
            // ramp
            case (bhv)
                0: tgt = duty_a_i;
                1: tgt = duty_loc_i;
                2: tgt = duty_b_i;
                3: tgt = 255;
                5: tgt = bigger(duty_loc_i, duty_b_i);
                6: tgt = bigger(duty_a_i, bigger(duty_loc_i, duty_b_i));
                7: tgt = m_man;
                default: tgt = 0;
            endcase
            if (off) begin m_ramp = 0; m_rdiv = 0; end
            else if (ms_tick_i) begin
                if (m_rdiv >= (((m_cfg >> 3) & 1) ? 3 : 0)) begin
                    m_rdiv = 0;
                    if (m_ramp < tgt) m_ramp++;
                    else if (m_ramp > tgt) m_ramp--;
                end else m_rdiv++;
            end
            // spin-up
            lim_ok = (m_lim != 0 && m_lim != 'hFFFF);
            hit = (tmo != 0) && ms_tick_i && (m_ms == ms_limit(tmo) - 1);
            n_state = m_state; n_edges = m_edges; n_ms = m_ms;
            n_force = ve ? 0 : m_force; n_fault = ve ? 0 : m_fault;
            if (m_state == 0) begin
                n_force = 0; n_fault = 0;
                if (!off) begin n_state = 1; n_edges = 0; n_ms = 0; end
            end else if (m_state == 1) begin
                if (off) begin n_state = 0; n_force = 0; n_fault = 0; end
                else if (ve && m_edges == 1) n_state = 2;
                else begin
                    if (ve) n_edges = 1;
                    if (ms_tick_i) n_ms = m_ms + 1;
                    if (hit) begin n_state = 2; n_force = 1; n_fault = lim_ok; end
                end
            end else if (off) begin
                n_state = 0; n_force = 0; n_fault = 0;
            end
            m_state = n_state; m_edges = n_edges; m_ms = n_ms;
            m_force = n_force; m_fault = n_fault;
            m_cfg = n_cfg; m_man = n_man; m_lim = n_lim;
        end
    end

    function automatic int exp_pwm();
        int off, full, duty, raw;
        off  = (((m_cfg >> 5) & 7) == 4);
        full = (m_state == 0 && !off) || m_state == 1;
        duty = off ? 0 : (full ? 255 : m_ramp);
        raw  = (duty == 255) || (m_cnt < duty);
        return raw ^ ((m_cfg >> 4) & 1);
    endfunction

    function automatic int exp_rd();
        case (addr_i)
            2'd0: return m_cfg;
            2'd1: return m_man;
            2'd2: return m_lim & 'hFF;
            default: return (m_lim >> 8) & 'hFF;
        endcase
    endfunction

    always @(posedge clk_i) begin
        #1;
        if (!rst_i && !done) begin
            chk("R7", "pwm_o", pwm_o, exp_pwm());
            chk("R5", "fan_fault_o", fan_fault_o, m_fault);
            chk("R4", "tach_period_o", tach_period_o, m_force ? 'hFFFF : m_period);
            chk("R1", "rd_data_o", rd_data_o, exp_rd());
        end
    end

    always @(negedge clk_i) begin
        if (tach_on) begin
            if (tach_cnt >= tach_half - 1) begin tach_r = ~tach_r; tach_cnt = 0; end
            else tach_cnt++;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
        @(negedge clk_i); wr_en_i = 1'b0; addr_i = 2'd0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
        @(negedge clk_i); addr_i = a; #1;
        chk(req, "register read", rd_data_o, exp);
        addr_i = 2'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic count_high(input int n, output int c);
        c = 0;
        repeat (n) begin @(negedge clk_i); c += pwm_o; end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk_i);
            cyc++;
            if (cyc > 100000) begin
                checks++; errs++;
                $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        int c;
        idle(4);
        rst_i = 1'b0;
        // R1 reset values
        idle(1);
        chk("R1", "reset pwm", pwm_o, 0);
        chk("R1", "reset fault", fan_fault_o, 0);
        chk("R1", "reset period", tach_period_o, 'hFFFF);
        rd_chk("R1", 2'd0, 'h82);
        rd_chk("R1", 2'd1, 'h00);
        rd_chk("R1", 2'd2, 'hFF);
        rd_chk("R1", 2'd3, 'hFF);

        // R2 R3 R5: spin-up timeout with a stalled fan, 100 ms code
        wr(2'd2, 8'h34); wr(2'd3, 8'h12);
        duty_a_i = 8'h40;
        wr(2'd0, 8'h01);
        count_high(95, c);
        chk("R3", "held full during spin-up", c, 95);
        chk("R2", "no fault before 100 ticks", fan_fault_o, 0);
        idle(15);
        chk("R2", "fault after 100 ticks", fan_fault_o, 1);
        chk("R4", "period forced after timeout", tach_period_o, 'hFFFF);

        // R4 R5 R6: fan starts turning
        tach_on = 1'b1;
        idle(200);
        chk("R5", "fault cleared by edges", fan_fault_o, 0);
        chk("R4", "tach period", tach_period_o, 40);
        count_high(256, c);
        chk("R6", "sensor A duty", c, 'h40);

        // R12 off mode
        wr(2'd0, 8'h80);
        chk("R12", "off output low", pwm_o, 0);
        wr(2'd0, 8'h90);
        count_high(20, c);
        chk("R12", "off inverted high", c, 20);

        // R3 spin-up with a running fan, local duty, 250 ms code
        duty_loc_i = 8'h80;
        wr(2'd0, 8'h22);
        count_high(38, c);
        chk("R3", "full before second edge", c, 38);
        idle(400);
        chk("R5", "no fault on good start", fan_fault_o, 0);
        count_high(256, c);
        chk("R6", "local duty", c, 'h80);

        // R6 R7 remaining codes
        duty_loc_i = 8'h30; duty_b_i = 8'h90; duty_a_i = 8'hA0;
        wr(2'd0, 8'hA2); idle(300); count_high(256, c);
        chk("R6", "max of local and B", c, 'h90);
        wr(2'd0, 8'h42); idle(300); count_high(256, c);
        chk("R6", "sensor B duty", c, 'h90);
        wr(2'd0, 8'hC2); idle(300); count_high(256, c);
        chk("R6", "max of all", c, 'hA0);
        wr(2'd0, 8'hD2); idle(10); count_high(256, c);
        chk("R7", "inverted duty", c, 256 - 'hA0);
        wr(2'd0, 8'h62); idle(300); count_high(256, c);
        chk("R7", "full speed constant high", c, 256);

        // R9 R8 manual duty and lock
        wr(2'd0, 8'hE2);
        wr(2'd1, 8'h55);
        rd_chk("R9", 2'd1, 'h55);
        idle(300); count_high(256, c);
        chk("R6", "manual duty", c, 'h55);
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h11);
        rd_chk("R9", 2'd1, 'h55);
        wr(2'd0, 8'hE2);
        lock_i = 1'b1;
        wr(2'd1, 8'h22);
        rd_chk("R9", 2'd1, 'h55);
        wr(2'd0, 8'h80);
        rd_chk("R8", 2'd0, 'hE2);
        lock_i = 1'b0;

        // R5 limit at all ones suppresses the fault
        wr(2'd0, 8'h80);
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        tach_on = 1'b0; tach_man = 1'b0;
        wr(2'd0, 8'h01);
        idle(200);
        chk("R5", "fault suppressed by limit", fan_fault_o, 0);
        chk("R4", "period forced without fault", tach_period_o, 'hFFFF);

        // R10 ramp speed
        wr(2'd0, 8'h80);
        tach_on = 1'b1;
        wr(2'd0, 8'h62);
        idle(300); count_high(256, c);
        chk("R10", "fast ramp reached full", c, 256);
        wr(2'd0, 8'h80);
        wr(2'd0, 8'h6A);
        idle(300); count_high(256, c);
        checks++;
        if (c >= 256) begin
            errs++;
            $display("FAIL R10 slow ramp actual=%0d expected=<256", c);
        end

        // R11 tach glitch rejection
        idle(100);
        chk("R4", "period before glitches", tach_period_o, 40);
        tach_on = 1'b0; tach_man = 1'b0;
        idle(60);
        repeat (3) begin
            @(negedge clk_i); tach_man = 1'b1;
            idle(3);
            tach_man = 1'b0;
            idle(10);
        end
        idle(10);
        chk("R11", "short pulses ignored", tach_period_o, 40);
        @(negedge clk_i); tach_man = 1'b1;
        idle(8);
        tach_man = 1'b0;
        idle(10);
        checks++;
        if (tach_period_o == 40) begin
            errs++;
            $display("FAIL R11 long pulse not counted actual=%0d expected=!40", tach_period_o);
        end

        idle(5);
        finish_run();
    end
endmodule